// File: doc/BRIEF.md
# Bus Activity Monitor with Consecutive-Breach Interrupts

The block watches a single stream of activity pulses. It divides time into sampling periods and adds a programmable weight to a running count for every cycle in which the activity input is high. At the end of each period the count is used three ways. It is folded into an exponential moving average. It is compared against an upper and a lower threshold, and a run of qualifying periods then raises a sticky interrupt flag. The new average is also compared against a separate pair of thresholds.

Software sets the block up through a register port that has a valid strobe and a write qualifier. A read returns data in the same cycle. Each consecutive-breach detector disarms itself when it fires. Software must set its arm bit again before it can fire a second time. The interrupt output is high while any status flag is set, and each flag is cleared by writing a one to it.

Top module: `amon_top`

## Requirements
- R1: After reset, the control register (0x40) reads 0, the period register (0x04) reads 11, the weight register (0x58) reads 0x400, the status register (0x64) and the global status register (0x00) read 0, and `irq` is low.
- R2: While control bits 31 (enable) and 18 (periodic) are both set, one sampling period lasts (period register + 1) × CYCLES_PER_UNIT clock cycles. Counting starts in the cycle after the enabling write. During the period, each cycle with `actEvent` high adds the weight register (0x58) to that period's count.
- R3: With control bit 30 armed, status bit 31 is set once the count is strictly greater than the upper threshold (0x44) for N consecutive periods. N−1 is held in control bits 28:26.
- R4: With control bit 29 armed, status bit 30 is set once the count is strictly less than the lower threshold (0x48) for N consecutive periods. N−1 is held in control bits 25:23. A period that does not meet the condition restarts that run from zero.
- R5: When a consecutive detector fires, it clears its own arm bit (30 for above, 29 for below), and the cleared bit reads back as 0. The detector does not fire again until software writes the arm bit back to 1.
- R6: At each period end, the average (read at 0x60) becomes avg + ((count − avg) >>> (K+1)), using signed arithmetic. K is held in control bits 12:10. The average is loaded from the initial-average register (0x4C) when a control write sets bit 31 while bit 31 was clear.
- R7: With control bit 21 set, status bit 29 is set at a period end when the new average is greater than 0x50. With control bit 20 set, status bit 28 is set at a period end when the new average is less than 0x54.
- R8: Writing to status register 0x64 clears each flag whose written bit is 1 and leaves flags written with 0 unchanged.
- R9: `irq` and bit 0 of the global status register are 1 exactly when at least one status flag (bits 31..28) is set.
- R10: Writing 0 to the control register stops sampling. While the block is stopped, activity changes neither the average nor the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| actEvent | input | 1 | Activity pulse; each high cycle adds one weight |
| cfgValid | input | 1 | Register access strobe |
| cfgWrite | input | 1 | 1 = write, 0 = read, qualified by cfgValid |
| cfgAddr | input | 7 | Register byte address |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, valid in the same cycle as a read strobe (0 otherwise) |
| irq | output | 1 | Level interrupt, high while any status flag is set |

## Verification
The assertions assume that software is the only agent that sets an arm bit. They also assume that a status flag falls only through a write to the status address, and that the average moves only while the channel is enabled or on an enabling write. The stimulus respects this by sending every register access through a single write task and a single read task, and by driving `actEvent` only on falling edges. Aligned runs start right after the enabling write, so the per-period event counts in the vector table match the period boundaries exactly. Free-running stretches hold `actEvent` high throughout, so every full period has the same count whatever its phase.

// File: rtl/amon_pkg.sv
`timescale 1ns/1ps
package amon_pkg;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int KW = 3;
  localparam int NUMW = 3;
  localparam int RUNW = NUMW + 1;
  localparam int NSTAT = 4;

  localparam logic [AW-1:0] ADDR_GSTAT  = 7'h00;
  localparam logic [AW-1:0] ADDR_PERIOD = 7'h04;
  localparam logic [AW-1:0] ADDR_CTRL   = 7'h40;
  localparam logic [AW-1:0] ADDR_UPPER  = 7'h44;
  localparam logic [AW-1:0] ADDR_LOWER  = 7'h48;
  localparam logic [AW-1:0] ADDR_INIT   = 7'h4C;
  localparam logic [AW-1:0] ADDR_AVGUP  = 7'h50;
  localparam logic [AW-1:0] ADDR_AVGLO  = 7'h54;
  localparam logic [AW-1:0] ADDR_WEIGHT = 7'h58;
  localparam logic [AW-1:0] ADDR_AVG    = 7'h60;
  localparam logic [AW-1:0] ADDR_STAT   = 7'h64;

  localparam int B_EN       = 31;
  localparam int B_UPARM    = 30;
  localparam int B_DNARM    = 29;
  localparam int B_UPNUM    = 26;
  localparam int B_DNNUM    = 23;
  localparam int B_AVGUPEN  = 21;
  localparam int B_AVGDNEN  = 20;
  localparam int B_PERIODIC = 18;
  localparam int B_K        = 10;

  localparam int S_TOP = 31;

  typedef struct packed {
    logic periodEnd;
    logic restart;
  } strobe_t;

  typedef struct packed {
    logic cntAbove;
    logic cntBelow;
    logic avgAbove;
    logic avgBelow;
  } cmp_t;

  typedef struct packed {
    logic [DW-1:0] upper;
    logic [DW-1:0] lower;
    logic [DW-1:0] initAvg;
    logic [DW-1:0] avgUp;
    logic [DW-1:0] avgLo;
    logic [DW-1:0] weight;
    logic [KW-1:0] k;
  } cfg_t;
endpackage

// File: rtl/amon_datapath.sv
`timescale 1ns/1ps
module amon_datapath
  import amon_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          actEvent,
  input  logic          running,
  input  strobe_t       strb,
  input  cfg_t          cfg,
  output cmp_t          cmp,
  output logic [DW-1:0] avgOut
);
  localparam int SHW = KW + 1;

  logic [DW-1:0]   accQ;
  logic [DW-1:0]   avgQ;
  logic [DW:0]     sum;
  logic [DW-1:0]   countNow;
  logic signed [DW:0] diff;
  logic signed [DW:0] step;
  logic [SHW-1:0]  shAmt;
  logic [DW-1:0]   avgNext;

  always_comb begin
    sum      = {1'b0, accQ} + (actEvent ? {1'b0, cfg.weight} : '0);
    countNow = sum[DW] ? '1 : sum[DW-1:0];
    shAmt    = {1'b0, cfg.k} + SHW'(1);
    diff     = $signed({1'b0, countNow}) - $signed({1'b0, avgQ});
    step     = diff >>> shAmt;
    avgNext  = avgQ + step[DW-1:0];
  end

  always_comb begin
    cmp.cntAbove = countNow > cfg.upper;
    cmp.cntBelow = countNow < cfg.lower;
    cmp.avgAbove = avgNext > cfg.avgUp;
    cmp.avgBelow = avgNext < cfg.avgLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      avgQ <= '0;
    end else if (strb.restart) begin
      accQ <= '0;
      avgQ <= cfg.initAvg;
    end else if (!running) begin
      accQ <= '0;
    end else if (strb.periodEnd) begin
      accQ <= '0;
      avgQ <= avgNext;
    end else begin
      accQ <= countNow;
    end
  end

  assign avgOut = avgQ;
endmodule

// File: rtl/amon_ctrl.sv
`timescale 1ns/1ps
module amon_ctrl
  import amon_pkg::*;
#(
  parameter int            CYCLES_PER_UNIT = 2,
  parameter int            PERIOD_W        = 16,
  parameter int            DEF_PERIOD      = 12,
  parameter logic [31:0]   DEF_WEIGHT      = 32'h400
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgValid,
  input  logic          cfgWrite,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgWdata,
  output logic [DW-1:0] cfgRdata,
  input  cmp_t          cmp,
  input  logic [DW-1:0] avgIn,
  output strobe_t       strb,
  output cfg_t          cfg,
  output logic          running,
  output logic [DW-1:0] ctrlOut,
  output logic [NSTAT-1:0] statOut,
  output logic          irq
);
  localparam int UNIT_W = (CYCLES_PER_UNIT > 1) ? $clog2(CYCLES_PER_UNIT) : 1;
  localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(CYCLES_PER_UNIT - 1);

  logic [PERIOD_W-1:0] periodQ;
  logic [DW-1:0]       ctrlQ, upperQ, lowerQ, initQ, avgUpQ, avgLoQ, weightQ;
  logic [NSTAT-1:0]    statQ;
  logic [UNIT_W-1:0]   unitCnt;
  logic [PERIOD_W-1:0] periodCnt;
  logic [RUNW-1:0]     upRun, dnRun, upNeed, dnNeed;
  logic                wrEn, ctrlWr, statWr, unitLast, periodEnd;
  logic                upArm, dnArm, upHit, dnHit;
  logic [NSTAT-1:0]    setVec, clrVec;

  // register write decode
  always_comb begin
    wrEn   = cfgValid && cfgWrite;
    ctrlWr = wrEn && (cfgAddr == ADDR_CTRL);
    statWr = wrEn && (cfgAddr == ADDR_STAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= PERIOD_W'(DEF_PERIOD - 1);
      upperQ  <= '0;
      lowerQ  <= '0;
      initQ   <= '0;
      avgUpQ  <= '0;
      avgLoQ  <= '0;
      weightQ <= DEF_WEIGHT;
    end else if (wrEn) begin
      case (cfgAddr)
        ADDR_PERIOD: periodQ <= cfgWdata[PERIOD_W-1:0];
        ADDR_UPPER:  upperQ  <= cfgWdata;
        ADDR_LOWER:  lowerQ  <= cfgWdata;
        ADDR_INIT:   initQ   <= cfgWdata;
        ADDR_AVGUP:  avgUpQ  <= cfgWdata;
        ADDR_AVGLO:  avgLoQ  <= cfgWdata;
        ADDR_WEIGHT: weightQ <= cfgWdata;
        default: ;
      endcase
    end
  end

  // period tick generator
  always_comb begin
    running   = ctrlQ[B_EN] && ctrlQ[B_PERIODIC];
    unitLast  = (unitCnt == UNIT_LAST);
    periodEnd = running && unitLast && (periodCnt >= periodQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitCnt   <= '0;
      periodCnt <= '0;
    end else if (!running) begin
      unitCnt   <= '0;
      periodCnt <= '0;
    end else if (unitLast) begin
      unitCnt   <= '0;
      periodCnt <= (periodCnt >= periodQ) ? '0 : periodCnt + 1'b1;
    end else begin
      unitCnt <= unitCnt + 1'b1;
    end
  end

  // consecutive-breach detectors
  always_comb begin
    upArm  = ctrlQ[B_UPARM];
    dnArm  = ctrlQ[B_DNARM];
    upNeed = RUNW'(ctrlQ[B_UPNUM +: NUMW]) + RUNW'(1);
    dnNeed = RUNW'(ctrlQ[B_DNNUM +: NUMW]) + RUNW'(1);
    upHit  = periodEnd && upArm && cmp.cntAbove && ((upRun + 1'b1) == upNeed);
    dnHit  = periodEnd && dnArm && cmp.cntBelow && ((dnRun + 1'b1) == dnNeed);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upRun <= '0;
      dnRun <= '0;
    end else begin
      if (!running || !upArm) upRun <= '0;
      else if (periodEnd) upRun <= (cmp.cntAbove && !upHit) ? upRun + 1'b1 : '0;
      if (!running || !dnArm) dnRun <= '0;
      else if (periodEnd) dnRun <= (cmp.cntBelow && !dnHit) ? dnRun + 1'b1 : '0;
    end
  end

  // control register: software write wins over self-disarm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= cfgWdata;
    end else begin
      if (upHit) ctrlQ[B_UPARM] <= 1'b0;
      if (dnHit) ctrlQ[B_DNARM] <= 1'b0;
    end
  end

  // sticky status with write-one-to-clear; a new event wins over a clear
  always_comb begin
    setVec = {upHit, dnHit,
              periodEnd && ctrlQ[B_AVGUPEN] && cmp.avgAbove,
              periodEnd && ctrlQ[B_AVGDNEN] && cmp.avgBelow};
    clrVec = statWr ? cfgWdata[S_TOP -: NSTAT] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrVec) | setVec;
  end

  assign irq = |statQ;

  // read mux, same-cycle data
  always_comb begin
    cfgRdata = '0;
    if (cfgValid && !cfgWrite) begin
      case (cfgAddr)
        ADDR_GSTAT:  cfgRdata = {{(DW-1){1'b0}}, irq};
        ADDR_PERIOD: cfgRdata = DW'(periodQ);
        ADDR_CTRL:   cfgRdata = ctrlQ;
        ADDR_UPPER:  cfgRdata = upperQ;
        ADDR_LOWER:  cfgRdata = lowerQ;
        ADDR_INIT:   cfgRdata = initQ;
        ADDR_AVGUP:  cfgRdata = avgUpQ;
        ADDR_AVGLO:  cfgRdata = avgLoQ;
        ADDR_WEIGHT: cfgRdata = weightQ;
        ADDR_AVG:    cfgRdata = avgIn;
        ADDR_STAT:   cfgRdata = {statQ, {(DW-NSTAT){1'b0}}};
        default:     cfgRdata = '0;
      endcase
    end
  end

  always_comb begin
    strb.periodEnd = periodEnd;
    strb.restart   = ctrlWr && cfgWdata[B_EN] && !ctrlQ[B_EN];
    cfg.upper   = upperQ;
    cfg.lower   = lowerQ;
    cfg.initAvg = initQ;
    cfg.avgUp   = avgUpQ;
    cfg.avgLo   = avgLoQ;
    cfg.weight  = weightQ;
    cfg.k       = ctrlQ[B_K +: KW];
  end

  assign ctrlOut = ctrlQ;
  assign statOut = statQ;
endmodule

// File: rtl/amon_top.sv
`timescale 1ns/1ps
module amon_top
  import amon_pkg::*;
#(
  parameter int          CYCLES_PER_UNIT = 2,
  parameter int          PERIOD_W        = 16,
  parameter int          DEF_PERIOD      = 12,
  parameter logic [31:0] DEF_WEIGHT      = 32'h400
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          actEvent,
  input  logic          cfgValid,
  input  logic          cfgWrite,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgWdata,
  output logic [DW-1:0] cfgRdata,
  output logic          irq
);
  strobe_t          strb;
  cfg_t             cfg;
  cmp_t             cmp;
  logic             running;
  logic             periodEnd;
  logic [DW-1:0]    avgVal;
  logic [DW-1:0]    ctrlVal;
  logic [NSTAT-1:0] statVal;

  amon_ctrl #(
    .CYCLES_PER_UNIT(CYCLES_PER_UNIT),
    .PERIOD_W(PERIOD_W),
    .DEF_PERIOD(DEF_PERIOD),
    .DEF_WEIGHT(DEF_WEIGHT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .cmp(cmp), .avgIn(avgVal), .strb(strb), .cfg(cfg), .running(running),
    .ctrlOut(ctrlVal), .statOut(statVal), .irq(irq)
  );

  amon_datapath u_dp (
    .clk(clk), .rstN(rstN), .actEvent(actEvent), .running(running),
    .strb(strb), .cfg(cfg), .cmp(cmp), .avgOut(avgVal)
  );

  assign periodEnd = strb.periodEnd;
endmodule

// File: rtl/amon_checker.sv
`timescale 1ns/1ps
module amon_checker
  import amon_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          cfgValid,
  input logic          cfgWrite,
  input logic [AW-1:0] cfgAddr,
  input logic          wTop,
  input logic          irq,
  input logic [2:0]    ctrlHi,
  input logic [NSTAT-1:0] statVal,
  input logic          periodEnd,
  input logic [DW-1:0] avgVal
);
  logic ctrlWrite, anyWrite;
  assign anyWrite  = cfgValid && cfgWrite;
  assign ctrlWrite = anyWrite && (cfgAddr == ADDR_CTRL);

  AST_UP_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statVal[3]) && !$past(ctrlWrite)) |-> !ctrlHi[1]); // R5

  AST_DN_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statVal[2]) && !$past(ctrlWrite)) |-> !ctrlHi[0]); // R5

  AST_SET_AT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(statVal & ~$past(statVal)) != 0) |-> $past(periodEnd)); // R3

  AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statVal[3]) |-> $past(anyWrite && cfgAddr == ADDR_STAT && wTop)); // R8

  AST_STOP_HOLDS_AVG: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlHi[2] && !anyWrite) |=> $stable(avgVal)); // R10

  AST_IRQ_RISE_AT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(periodEnd)); // R9
endmodule

bind amon_top amon_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
  .cfgAddr(cfgAddr), .wTop(cfgWdata[31]), .irq(irq),
  .ctrlHi(ctrlVal[31:29]), .statVal(statVal), .periodEnd(periodEnd),
  .avgVal(avgVal)
);

// File: tb/amon_top_tb.sv
`timescale 1ns/1ps
module amon_top_tb;
  localparam int CPU  = 2;
  localparam int PREG = 3;
  localparam int LEN  = CPU * (PREG + 1);
  localparam int WGT  = 16;
  localparam int NVEC = 12;
  // {events per period, expected above flag, expected below flag}
  localparam logic [5:0] VEC [NVEC] = '{
    {4'd7, 2'b00}, {4'd2, 2'b00}, {4'd8, 2'b00}, {4'd6, 2'b10},
    {4'd0, 2'b10}, {4'd1, 2'b10}, {4'd5, 2'b10}, {4'd0, 2'b10},
    {4'd0, 2'b10}, {4'd0, 2'b11}, {4'd8, 2'b11}, {4'd8, 2'b11}};

  localparam logic [31:0] C_EN = 32'h8000_0000, C_UPARM = 32'h4000_0000,
    C_DNARM = 32'h2000_0000, C_AVGUP = 32'h0020_0000, C_AVGDN = 32'h0010_0000,
    C_PER = 32'h0004_0000;

  logic clk = 1'b0, rstN = 1'b0, actEvent = 1'b0;
  logic cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [6:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0, cfgRdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  longint modelAvg;

  amon_top #(.CYCLES_PER_UNIT(CPU)) u_dut (
    .clk(clk), .rstN(rstN), .actEvent(actEvent), .cfgValid(cfgValid),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b1; cfgAddr = a; cfgWdata = d;
    @(posedge clk);
    #0.2 cfgValid = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    cfgValid = 1'b1; cfgWrite = 1'b0; cfgAddr = a;
    #0.2 d = cfgRdata;
    cfgValid = 1'b0;
  endtask

  // one aligned period: n event cycles then idle; returns just after the period-end edge
  task automatic runPeriod(input int n);
    for (int c = 0; c < LEN; c++) begin
      @(negedge clk);
      actEvent = (c < n);
    end
    @(posedge clk);
    #0.2;
  endtask

  task automatic runFree(input int cycles, input logic e);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      actEvent = e;
    end
    @(negedge clk);
    actEvent = 1'b0;
  endtask

  function automatic longint nextAvg(input longint a, input longint cnt, input int k);
    longint d;
    d = cnt - a;
    return a + (d >>> (k + 1));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] a0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(7'h40, d); chk("R1 ctrl", d, 32'h0);
    rd(7'h04, d); chk("R1 period", d, 32'd11);
    rd(7'h58, d); chk("R1 weight", d, 32'h400);
    rd(7'h64, d); chk("R1 status", d, 32'h0);
    rd(7'h00, d); chk("R1 gstatus", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // configuration: above N=2, below N=3, K=1
    wr(7'h04, PREG);
    wr(7'h58, WGT);
    wr(7'h44, 32'd80);
    wr(7'h48, 32'd32);
    wr(7'h4C, 32'd64);
    wr(7'h40, C_EN | C_PER | C_UPARM | C_DNARM | (32'd1 << 26) | (32'd2 << 23) | (32'd1 << 10));
    rd(7'h60, d); chk("R6 init load", d, 32'd64);
    modelAvg = 64;

    for (int i = 0; i < NVEC; i++) begin
      int n;
      n = int'(VEC[i][5:2]);
      runPeriod(n);
      modelAvg = nextAvg(modelAvg, longint'(n * WGT), 1);
      rd(7'h60, d); chk($sformatf("R6 R2 avg vec%0d", i), d, 32'(modelAvg));
      rd(7'h64, d);
      chk($sformatf("R3 above vec%0d", i), {31'b0, d[31]}, {31'b0, VEC[i][1]});
      chk($sformatf("R4 below vec%0d", i), {31'b0, d[30]}, {31'b0, VEC[i][0]});
      chk($sformatf("R9 irq vec%0d", i), {31'b0, irq}, {31'b0, VEC[i][1] | VEC[i][0]});
    end

    rd(7'h40, d);
    chk("R5 arm bits cleared", {29'b0, d[31:29]}, 32'd4);

    wr(7'h64, 32'h8000_0000);
    #0.2;
    rd(7'h64, d); chk("R8 partial clear", d, 32'h4000_0000);
    chk("R9 irq still high", {31'b0, irq}, 32'h1);
    rd(7'h00, d); chk("R9 gstatus set", d, 32'h1);
    wr(7'h64, 32'h4000_0000);
    #0.2;
    rd(7'h64, d); chk("R8 full clear", d, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    rd(7'h00, d); chk("R9 gstatus clear", d, 32'h0);

    // disarmed: sustained high activity must not fire
    runFree(3 * LEN, 1'b1);
    rd(7'h64, d); chk("R5 no refire while disarmed", d, 32'h0);

    // re-arm above detector
    wr(7'h40, C_EN | C_PER | C_UPARM | (32'd1 << 26) | (32'd1 << 10));
    runFree(3 * LEN, 1'b1);
    rd(7'h64, d); chk("R5 rearmed fires", d, 32'h8000_0000);

    // stop
    wr(7'h40, 32'h0);
    #0.2;
    rd(7'h60, a0);
    runFree(3 * LEN, 1'b1);
    rd(7'h60, d); chk("R10 avg frozen", d, a0);
    rd(7'h64, d); chk("R10 status unchanged", d, 32'h8000_0000);

    // average watermarks
    wr(7'h64, 32'hFFFF_FFFF);
    wr(7'h50, 32'd50);
    wr(7'h54, 32'd70);
    wr(7'h40, C_EN | C_PER | C_AVGUP | C_AVGDN | (32'd1 << 10));
    rd(7'h60, d); chk("R6 reload on enable", d, 32'd64);
    runPeriod(8);
    rd(7'h60, d); chk("R6 avg rise", d, 32'd80);
    rd(7'h64, d); chk("R7 avg above only", d, 32'h2000_0000);
    runPeriod(0);
    rd(7'h60, d); chk("R6 avg fall", d, 32'd60);
    rd(7'h64, d); chk("R7 avg below", d, 32'h3000_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule